// File: doc/BRIEF.md
# SDRAM Clock-Enable State Monitor

This block watches the control pins of an SDRAM device and follows its power-related state from the outside. On each clock it takes the clock-enable level, the four active-low command strobes (chip select, row strobe, column strobe, write enable) and an all-banks-idle status that some other part of the controller supplies. It then reports whether the device is active, idle with all banks closed, in power-down, in self-refresh, or in clock suspend.

Each transition depends on two clock-enable samples: the one held from the previous cycle and the one on the pins now. Low-power modes and mode-register writes may only start from the all-banks-idle condition. When a low-power mode is left, only quiet commands are accepted for a settling interval. Commands that break these rules raise a one-cycle illegal pulse. A clock-enable that was high while the device is meant to be asleep raises a one-cycle invalid pulse. Both pulses are registered, as is the state.

Top module: `sdram_cke_monitor`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the state is idle (code 1) and both pulse outputs are low. The held clock-enable sample starts high.
- R2: Commands are decoded from {cs_n,ras_n,cas_n,we_n}. cs_n high is deselect, 0111 is no-operation, 0001 is auto-refresh and 0000 is mode-register write. Deselect and no-operation count as quiet commands.
- R3: From a normal state with banks_idle high, a held-high then current-low clock-enable with auto-refresh moves the state to self-refresh (code 3).
- R4: Under the same conditions, a quiet command moves the state to power-down (code 2).
- R5: In power-down or self-refresh, a clock-enable low in both cycles keeps the state whatever the command is, with no pulse.
- R6: In power-down or self-refresh, a low-then-high clock-enable with a quiet command moves the state to idle (code 1).
- R7: In power-down or self-refresh, a low-then-high clock-enable with any non-quiet command pulses illegal_o and the state stays where it is.
- R8: In power-down or self-refresh, a held clock-enable sample that is high pulses invalid_o and the state stays where it is.
- R9: With banks_idle low, a high-then-low clock-enable with auto-refresh or mode-register write pulses illegal_o. A mode-register write with clock-enable high in both cycles also pulses illegal_o.
- R10: From a normal state, high-then-low with a command that enters no other mode starts clock suspend (code 4). With banks_idle high, a mode-register write instead stays idle. Clock-enable low keeps suspend, and clock-enable high leaves it for the normal state.
- R11: After an exit from power-down or self-refresh, the next SETUP_CYC cycles spent outside the low-power states accept only quiet commands. Any other command pulses illegal_o.
- R12: In a normal state with clock-enable high in both cycles, the state follows banks_idle: idle (1) when it is high, active (0) when it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock-enable pin level this cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| banks_idle | input | 1 | External status: all banks closed |
| state_o | output | 3 | Registered state: 0 active, 1 idle, 2 power-down, 3 self-refresh, 4 suspend |
| illegal_o | output | 1 | One-cycle pulse on an illegal command |
| invalid_o | output | 1 | One-cycle pulse on an invalid clock-enable sequence |

## Verification
The bench builds the monitor with SETUP_CYC set to 2, not the default of 1. With that value, a non-quiet command in the second cycle after an exit is flagged, and the same command one cycle later passes. This shows that the window counts down and closes, and is not a single delayed check. Both low-power modes are taken through entry, maintain, legal exit, illegal exit and the invalid-level case that follows it. Suspend is entered from both the active and the idle condition.

// File: rtl/sdram_cke_monitor.sv
module sdram_cke_monitor #(
  parameter int SETUP_CYC = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       banks_idle,
  output logic [2:0] state_o,
  output logic       illegal_o,
  output logic       invalid_o
);
  localparam int CW = (SETUP_CYC < 1) ? 1 : $clog2(SETUP_CYC + 1);
  localparam logic [CW-1:0] WIN_LOAD = CW'(SETUP_CYC);

  localparam logic [2:0] S_ACT  = 3'd0;
  localparam logic [2:0] S_IDLE = 3'd1;
  localparam logic [2:0] S_PD   = 3'd2;
  localparam logic [2:0] S_SR   = 3'd3;
  localparam logic [2:0] S_SUSP = 3'd4;

  logic [2:0]    state_q, state_d;
  logic          cke_q;
  logic [CW-1:0] win_q, win_d;
  logic          ill_d, inv_d;

  wire quiet  = cs_n | (ras_n & cas_n & we_n);
  wire aref   = !cs_n & !ras_n & !cas_n & we_n;
  wire mrs    = !cs_n & !ras_n & !cas_n & !we_n;
  wire lowpwr = (state_q == S_PD) || (state_q == S_SR);
  wire [2:0] norm_st = banks_idle ? S_IDLE : S_ACT;

  always_comb begin
    state_d = state_q;
    win_d   = win_q;
    ill_d   = 1'b0;
    inv_d   = 1'b0;
    if (win_q != '0 && !lowpwr) begin
      win_d = win_q - 1'b1;
      if (!quiet) ill_d = 1'b1;
    end
    case (state_q)
      S_PD, S_SR: begin
        if (cke_q) inv_d = 1'b1;
        else if (cke) begin
          if (quiet) begin
            state_d = S_IDLE;
            win_d   = WIN_LOAD;
          end else ill_d = 1'b1;
        end
      end
      S_SUSP: if (cke) state_d = norm_st;
      default: begin
        if (cke) begin
          state_d = norm_st;
          if (mrs && !banks_idle) ill_d = 1'b1;
        end else if (banks_idle) begin
          if (aref)       state_d = S_SR;
          else if (quiet) state_d = S_PD;
          else if (mrs)   state_d = S_IDLE;
          else            state_d = S_SUSP;
        end else begin
          if (aref || mrs) ill_d = 1'b1;
          state_d = S_SUSP;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      cke_q     <= 1'b1;
      win_q     <= '0;
      illegal_o <= 1'b0;
      invalid_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      cke_q     <= cke;
      win_q     <= win_d;
      illegal_o <= ill_d;
      invalid_o <= inv_d;
    end
  end

  assign state_o = state_q;
endmodule

module sdram_cke_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cke,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic       banks_idle,
  input logic [2:0] state_o,
  input logic       illegal_o,
  input logic       invalid_o,
  input logic       cke_q
);
  wire c_quiet = cs_n | (ras_n & cas_n & we_n);
  wire c_aref  = !cs_n & !ras_n & !cas_n & we_n;
  wire c_lp    = (state_o == 3'd2) || (state_o == 3'd3);
  wire c_norm  = (state_o == 3'd0) || (state_o == 3'd1);

  assert_sr_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (c_norm && banks_idle && cke_q && !cke && c_aref) |=> state_o == 3'd3);

  assert_lp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_lp && !cke_q && !cke) |=> (state_o == $past(state_o)) && !illegal_o && !invalid_o);

  assert_lp_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (c_lp && !cke_q && cke && c_quiet) |=> (state_o == 3'd1) && !illegal_o);

  assert_bad_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (c_lp && !cke_q && cke && !c_quiet) |=> illegal_o && (state_o == $past(state_o)));

  assert_high_in_lp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (c_lp && cke_q) |=> invalid_o);

  assert_susp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4 && !cke) |=> state_o == 3'd4);
endmodule

bind sdram_cke_monitor sdram_cke_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .banks_idle(banks_idle), .state_o(state_o),
  .illegal_o(illegal_o), .invalid_o(invalid_o), .cke_q(cke_q)
);

// File: tb/sdram_cke_monitor_tb.sv
module sdram_cke_monitor_tb;
  localparam int SETUP = 2;
  localparam logic [3:0] DESEL = 4'b1111, NOP = 4'b0111, AREF = 4'b0001,
                         MRS = 4'b0000, ACT = 4'b0011, RD = 4'b0101;

  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1, bi = 1'b1;
  logic [3:0] cmd = NOP;
  logic [2:0] state_o;
  logic illegal_o, invalid_o;
  int checks = 0, failures = 0;
  bit done = 0;

  int m_st, m_prev, m_win, e_ill, e_inv;

  always #2 clk = ~clk;

  sdram_cke_monitor #(.SETUP_CYC(SETUP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cmd[3]), .ras_n(cmd[2]),
    .cas_n(cmd[1]), .we_n(cmd[0]), .banks_idle(bi), .state_o(state_o),
    .illegal_o(illegal_o), .invalid_o(invalid_o)
  );

  task automatic compare(string req, int st, int il, int iv);
    checks++;
    if (state_o !== 3'(st) || illegal_o !== 1'(il) || invalid_o !== 1'(iv)) begin
      failures++;
      $display("FAIL %s: state/ill/inv actual %0d/%0d/%0d expected %0d/%0d/%0d",
               req, state_o, illegal_o, invalid_o, st, il, iv);
    end
  endtask

  task automatic model_reset();
    m_st = 1; m_prev = 1; m_win = 0; e_ill = 0; e_inv = 0;
  endtask

  // reference: one clock of the rules stated in R2..R12
  task automatic model_step(int k, logic [3:0] c, int idle);
    bit q, ar, mr, asleep;
    int nst;
    q  = (c[3] == 1'b1) || (c[2:0] == 3'b111);
    ar = (c == AREF);
    mr = (c == MRS);
    asleep = (m_st == 2 || m_st == 3);
    nst = m_st; e_ill = 0; e_inv = 0;
    if (!asleep && m_win > 0) begin
      m_win--;
      if (!q) e_ill = 1;
    end
    if (asleep) begin
      if (m_prev == 1) e_inv = 1;
      else if (k == 1 && q) begin nst = 1; m_win = SETUP; end
      else if (k == 1) e_ill = 1;
    end else if (m_st == 4) begin
      if (k == 1) nst = idle ? 1 : 0;
    end else if (k == 1) begin
      nst = idle ? 1 : 0;
      if (mr && !idle) e_ill = 1;
    end else if (!idle) begin
      nst = 4;
      if (ar || mr) e_ill = 1;
    end else nst = ar ? 3 : q ? 2 : mr ? 1 : 4;
    m_st = nst; m_prev = k;
  endtask

  task automatic step(string req, int k, logic [3:0] c, int idle);
    cke = 1'(k); cmd = c; bi = 1'(idle);
    model_step(k, c, idle);
    @(posedge clk);
    @(negedge clk);
    compare(req, m_st, e_ill, e_inv);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1", 1, 0, 0);
    rst_n = 1'b1;
    step("R12", 1, NOP, 1);
    step("R12", 1, ACT, 0);
    step("R9",  1, MRS, 0);
    step("R9",  0, AREF, 0);
    step("R10", 0, NOP, 0);
    step("R10", 1, NOP, 0);
    step("R12", 1, NOP, 1);
    step("R10", 0, ACT, 1);
    step("R10", 1, NOP, 1);
    step("R4",  0, NOP, 1);
    step("R5",  0, RD, 1);
    step("R5",  0, MRS, 1);
    step("R6",  1, DESEL, 1);
    step("R11", 1, NOP, 1);
    step("R11", 1, RD, 1);
    step("R11", 1, RD, 1);
    step("R3",  0, AREF, 1);
    step("R5",  0, ACT, 1);
    step("R7",  1, RD, 1);
    step("R8",  1, NOP, 1);
    step("R8",  0, NOP, 1);
    step("R6",  1, NOP, 1);
    step("R11", 1, MRS, 1);
    step("R11", 1, NOP, 1);
    step("R2",  1, MRS, 1);
    step("R10", 0, MRS, 1);
    step("R12", 1, NOP, 1);
    step("R4",  0, DESEL, 1);
    step("R7",  1, AREF, 1);
    step("R8",  1, NOP, 1);
    step("R8",  0, DESEL, 1);
    step("R6",  1, NOP, 1);
    step("R12", 1, NOP, 0);
    step("R9",  0, MRS, 0);
    step("R10", 1, NOP, 1);
    rst_n = 1'b0;
    model_reset();
    @(posedge clk); @(negedge clk);
    compare("R1", 1, 0, 0);
    rst_n = 1'b1;
    step("R1", 1, NOP, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule